// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD. It holds seven fields: seconds, minutes, hours on a 24-hour range, a day-of-week index, day of month, month and a two-digit year. A built-in prescaler turns a reference-rate enable pulse (nominally 32768 per second) into a one-second tick. The same prescaler gives a square-wave tap at a lower audio rate, which a host can observe to trim the oscillator. Every tick advances the seconds, and carries ripple through all the fields in that same cycle. The length of each month comes from the month and the year, so February gets 29 days in leap years. The rule treats every two-digit year divisible by four as leap, which is correct from 2000 through 2099.

A register front end commits new settings through a parallel load port. One pulse on `load_en` replaces all seven fields at once and restarts the one-second phase. When the run flag is low, the prescaler, the tap and the fields all hold their values, so the counter can be parked without losing its state.

Top module: `bcd_calendar`

## Requirements
- R1: While rst_n is low the fields read second 00, minute 00, hour 00, weekday 01, date 01, month 01, year 00, with tap_out 0 and sec_tick 0.
- R2: Seconds and minutes count 00 to 59 in BCD. A seconds wrap adds one minute, and a minutes wrap adds one hour in the same tick.
- R3: Hours count 00 to 23 in BCD. An hour wrap advances both the weekday and the date in the same tick.
- R4: The weekday counts 01 to 07, and 07 is followed by 01.
- R5: The date after the last day of the month is 01, and the month then advances. Months 04, 06, 09 and 11 have 30 days. Month 02 follows R6. All other months have 31 days.
- R6: February has 29 days when the BCD year, read as a decimal number, is divisible by 4 (00 included), and 28 days otherwise.
- R7: Month 12 is followed by month 01 with the year plus one, and year 99 is followed by 00.
- R8: While osc_run is 0, sec_tick stays 0 and the fields, the prescaler phase and tap_out hold their values, whatever ref_tick does.
- R9: A cycle with load_en high loads the ld_* values into all fields at the next clock edge, even if osc_run is 0. This load suppresses any tick in that cycle and clears the prescaler phase, so the next tick comes REF_HZ counted ref_tick pulses later.
- R10: sec_tick is high, without a register, in the cycle where osc_run and ref_tick are both high and this is the REF_HZ-th counted ref_tick pulse since reset, load or the last tick. The fields advance at the edge that ends that cycle.
- R11: tap_out toggles after every REF_HZ/(2*TAP_HZ) counted ref_tick pulses. A load does not change its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the reference rate |
| osc_run | input | 1 | 1 lets the prescaler and the counter run |
| load_en | input | 1 | Loads all ld_* fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_wday | input | 8 | Weekday to load (01 to 07) |
| ld_date | input | 8 | BCD day of month to load |
| ld_mon | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| cur_sec | output | 8 | BCD seconds |
| cur_min | output | 8 | BCD minutes |
| cur_hour | output | 8 | BCD hours |
| cur_wday | output | 8 | Weekday |
| cur_date | output | 8 | BCD day of month |
| cur_mon | output | 8 | BCD month |
| cur_year | output | 8 | BCD year |
| sec_tick | output | 1 | One-second tick (see R10) |
| tap_out | output | 1 | Square wave at TAP_HZ |

## Verification
A free run from reset over more than a minute checks BCD digit carries and the seconds-to-minutes wrap. Loads placed one or two seconds before midnight on chosen dates check each month length. These cover 30-day, 31-day, leap and non-leap Februaries, the year 00 and the wrap from year 99, which tells apart a wrong month table, a wrong leap test and a missing cascade. A stretch with osc_run low under active reference pulses checks the hold. A load placed in the exact cycle of a tick checks the priority of the load and the restart of the prescaler phase. An irregular ref_tick pattern shows that the prescaler counts pulses, not clock cycles.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    localparam logic [7:0] SEC_LAST  = 8'h59;
    localparam logic [7:0] MIN_LAST  = 8'h59;
    localparam logic [7:0] HOUR_LAST = 8'h23;
    localparam logic [7:0] WDAY_LAST = 8'h07;
    localparam logic [7:0] MON_LAST  = 8'h12;
    localparam logic [7:0] YEAR_LAST = 8'h99;
    localparam logic [7:0] FIRST_ONE = 8'h01;

    localparam cal_t CAL_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                   wday: 8'h01, hour: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    // Adds one to a two-digit packed BCD value
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int REF_HZ = 32768,
    parameter int TAP_HZ = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic osc_run,
    input  logic clr,
    output logic tick,
    output logic tap
);
    localparam int DW       = (REF_HZ > 2) ? $clog2(REF_HZ) : 1;
    localparam int TAP_HALF = REF_HZ / (2 * TAP_HZ);
    localparam int TW       = (TAP_HALF > 2) ? $clog2(TAP_HALF) : 1;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [TW-1:0] tc;
        logic          tap;
    } ps_t;

    ps_t ps_d, ps_q;
    logic adv;

    always_comb begin
        ps_d = ps_q;
        adv  = osc_run && ref_tick;
        tick = 1'b0;
        if (clr) begin
            ps_d.div = '0;
        end else if (adv) begin
            if (ps_q.div == DW'(REF_HZ - 1)) begin
                ps_d.div = '0;
                tick     = 1'b1;
            end else begin
                ps_d.div = ps_q.div + 1'b1;
            end
        end
        if (adv) begin
            if (ps_q.tc == TW'(TAP_HALF - 1)) begin
                ps_d.tc  = '0;
                ps_d.tap = ~ps_q.tap;
            end else begin
                ps_d.tc = ps_q.tc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign tap = ps_q.tap;

    // R8
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_run && ref_tick) |=> $stable(tap));

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [7:0] mon,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [7:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
        leap     = (year_bin[1:0] == 2'b00);
        case (mon)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int REF_HZ = 32768,
    parameter int TAP_HZ = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       osc_run,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] cur_sec,
    output logic [7:0] cur_min,
    output logic [7:0] cur_hour,
    output logic [7:0] cur_wday,
    output logic [7:0] cur_date,
    output logic [7:0] cur_mon,
    output logic [7:0] cur_year,
    output logic       sec_tick,
    output logic       tap_out
);
    cal_t cal_d, cal_q;
    logic [7:0] last_date;

    cal_prescaler #(.REF_HZ(REF_HZ), .TAP_HZ(TAP_HZ)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .osc_run  (osc_run),
        .clr      (load_en),
        .tick     (sec_tick),
        .tap      (tap_out)
    );

    cal_month_len u_mlen (
        .mon       (cal_q.mon),
        .year      (cal_q.year),
        .last_date (last_date)
    );

    always_comb begin
        cal_d = cal_q;
        if (load_en) begin
            cal_d = '{year: ld_year, mon: ld_mon, date: ld_date, wday: ld_wday,
                      hour: ld_hour, min: ld_min, sec: ld_sec};
        end else if (sec_tick) begin
            if (cal_q.sec != SEC_LAST) begin
                cal_d.sec = bcd_inc(cal_q.sec);
            end else begin
                cal_d.sec = 8'h00;
                if (cal_q.min != MIN_LAST) begin
                    cal_d.min = bcd_inc(cal_q.min);
                end else begin
                    cal_d.min = 8'h00;
                    if (cal_q.hour != HOUR_LAST) begin
                        cal_d.hour = bcd_inc(cal_q.hour);
                    end else begin
                        cal_d.hour = 8'h00;
                        cal_d.wday = (cal_q.wday == WDAY_LAST) ? FIRST_ONE
                                                               : bcd_inc(cal_q.wday);
                        if (cal_q.date != last_date) begin
                            cal_d.date = bcd_inc(cal_q.date);
                        end else begin
                            cal_d.date = FIRST_ONE;
                            if (cal_q.mon != MON_LAST) begin
                                cal_d.mon = bcd_inc(cal_q.mon);
                            end else begin
                                cal_d.mon  = FIRST_ONE;
                                cal_d.year = (cal_q.year == YEAR_LAST) ? 8'h00
                                                                       : bcd_inc(cal_q.year);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    assign cur_sec  = cal_q.sec;
    assign cur_min  = cal_q.min;
    assign cur_hour = cal_q.hour;
    assign cur_wday = cal_q.wday;
    assign cur_date = cal_q.date;
    assign cur_mon  = cal_q.mon;
    assign cur_year = cal_q.year;

    // R8
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run && !load_en) |=> $stable(cal_q));

    // R9
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cur_sec == $past(ld_sec) && cur_min == $past(ld_min) &&
                     cur_hour == $past(ld_hour) && cur_wday == $past(ld_wday) &&
                     cur_date == $past(ld_date) && cur_mon == $past(ld_mon) &&
                     cur_year == $past(ld_year)));

    // R5
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cur_date >= 8'h01 && cur_date <= last_date));

    // R3
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cur_hour <= HOUR_LAST));

endmodule

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
    localparam int REF  = 4;
    localparam int TAPH = 1;
    localparam int HALF = REF / (2 * TAPH);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, ref_tick = 1'b0, osc_run = 1'b0, load_en = 1'b0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0;
    logic [7:0] ld_date = 0, ld_mon = 0, ld_year = 0;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_wday, cur_date, cur_mon, cur_year;
    logic sec_tick, tap_out;

    bcd_calendar #(.REF_HZ(REF), .TAP_HZ(TAPH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_run(osc_run),
        .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_date(cur_date), .cur_mon(cur_mon),
        .cur_year(cur_year), .sec_tick(sec_tick), .tap_out(tap_out));

    int tests = 0, fails = 0;
    string req = "R1";

    // behavioural reference state
    int ms = 0, mm = 0, mh = 0, mw = 1, md = 1, mmo = 1, my = 0;
    int mdiv = 0, mtc = 0;
    logic mtap = 1'b0;

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string f, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, f, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("sec", cur_sec, bcd(ms));
        chk("min", cur_min, bcd(mm));
        chk("hour", cur_hour, bcd(mh));
        chk("wday", cur_wday, bcd(mw));
        chk("date", cur_date, bcd(md));
        chk("mon", cur_mon, bcd(mmo));
        chk("year", cur_year, bcd(my));
        chk("tap", {7'd0, tap_out}, {7'd0, mtap});
    endtask

    task automatic model_second();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw == 7) ? 1 : mw + 1;
                    if (md == month_days(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1;
                            my = (my + 1) % 100;
                        end
                    end else begin
                        md++;
                    end
                end
            end
        end
    endtask

    task automatic step(input logic r, input logic run, input logic ld);
        logic exp_tick;
        @(negedge clk);
        ref_tick = r; osc_run = run; load_en = ld;
        #1;
        exp_tick = run && r && !ld && (mdiv == REF - 1);
        // R10: combinational tick in the cycle of the REF-th counted pulse
        chk("sec_tick", {7'd0, sec_tick}, {7'd0, exp_tick});
        @(posedge clk);
        if (ld) begin
            ms = unbcd(ld_sec); mm = unbcd(ld_min); mh = unbcd(ld_hour);
            mw = unbcd(ld_wday); md = unbcd(ld_date); mmo = unbcd(ld_mon);
            my = unbcd(ld_year); mdiv = 0;
        end else if (run && r) begin
            if (mdiv == REF - 1) begin
                mdiv = 0;
                model_second();
            end else begin
                mdiv++;
            end
        end
        if (run && r) begin
            if (mtc == HALF - 1) begin
                mtc = 0; mtap = ~mtap;
            end else begin
                mtc++;
            end
        end
        #2;
        compare_all();
    endtask

    task automatic run_secs(input int n);
        for (int i = 0; i < n * REF; i++) step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic load_time(input int y, input int mo, input int d, input int w,
                             input int h, input int mi, input int s);
        ld_year = bcd(y); ld_mon = bcd(mo); ld_date = bcd(d); ld_wday = bcd(w);
        ld_hour = bcd(h); ld_min = bcd(mi); ld_sec = bcd(s);
        step(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset values
        req = "R1";
        repeat (2) @(negedge clk);
        #1;
        compare_all();
        chk("sec_tick", {7'd0, sec_tick}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: free run past a minute
        req = "R2";
        run_secs(70);

        // R3 R4 R5: April 30 at midnight, weekday 07 wraps
        req = "R5";
        load_time(23, 4, 30, 7, 23, 59, 58);
        run_secs(3);
        // R5: a 31-day month passes through date 31
        load_time(23, 1, 30, 2, 23, 59, 59);
        run_secs(2);
        load_time(23, 1, 31, 3, 23, 59, 59);
        run_secs(2);

        // R6: leap and common Februaries
        req = "R6";
        load_time(24, 2, 28, 4, 23, 59, 59);
        run_secs(2);
        load_time(24, 2, 29, 5, 23, 59, 59);
        run_secs(2);
        load_time(23, 2, 28, 1, 23, 59, 59);
        run_secs(2);
        load_time(0, 2, 28, 1, 23, 59, 59);
        run_secs(2);

        // R7: end of year and year 99
        req = "R7";
        load_time(99, 12, 31, 6, 23, 59, 59);
        run_secs(2);
        load_time(41, 12, 31, 6, 23, 59, 59);
        run_secs(2);

        // R3 R4: hour wrap moves weekday and date
        req = "R3";
        load_time(50, 6, 15, 7, 23, 59, 59);
        run_secs(2);

        // R8: stopped oscillator ignores reference pulses
        req = "R8";
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0);
        run_secs(1);

        // R9: load in the same cycle as a tick
        req = "R9";
        while (mdiv != REF - 1) step(1'b1, 1'b1, 1'b0);
        load_time(10, 10, 10, 3, 10, 10, 10);
        run_secs(2);
        // R9: load while stopped still takes effect
        ld_sec = 8'h33;
        step(1'b1, 1'b0, 1'b1);

        // R10 R11: irregular reference pulses
        req = "R10";
        for (int i = 0; i < 60; i++) step(((i % 3) != 1), 1'b1, 1'b0);
        req = "R11";
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule